// File: doc/BRIEF.md
# Program Counter Unit with Memory-Vectored Start

This block holds the 16-bit address of the next instruction for a small 8-bit processor. During normal execution it moves forward by the byte length of each fetched instruction. It can also be loaded with a branch target. The target comes from one of two sources: an immediate operand or a register value.

The counter does not clear to a fixed start address when it leaves reset. It first reads a two-byte start vector from memory, one byte per cycle, using a byte-wide read port. The byte at 0000H is the low half and the byte at 0001H is the high half. The counter takes the assembled vector and then raises `ready_o`. Surrounding control logic must wait for `ready_o` before it issues fetch-advance or branch requests. Any request made earlier is dropped.

Top module: `pc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0000H, `ready_o` is 0, `mem_rd_o` is 1 and `mem_addr_o` is 0000H.
- R2: The first clock edge after reset release takes `mem_data_i` as the low vector byte (address 0000H). During the following cycle `mem_addr_o` is 0001H and `mem_rd_o` stays 1. Once `ready_o` is high, `mem_rd_o` is 0.
- R3: On the second clock edge after reset release, `pc_o` becomes {byte read at 0001H, byte read at 0000H} and `ready_o` becomes 1.
- R4: While `ready_o` is 0, `fetch_i` and `br_ld_i` have no effect on `pc_o`.
- R5: When `ready_o` is 1, `fetch_i` is 1 and `br_ld_i` is 0, `pc_o` advances after the next edge by `ilen_i`+1. The encoding is 00 = 1 byte, 01 = 2, 10 = 3, 11 = 4.
- R6: The advance wraps modulo 65536. For example, FFFEH plus 4 gives 0002H.
- R7: When `ready_o` is 1 and `br_ld_i` is 1, `pc_o` loads after the next edge. It takes `br_imm_i` when `br_sel_i` is 0 and `br_reg_i` when `br_sel_i` is 1.
- R8: When `br_ld_i` and `fetch_i` are both 1 in the same cycle, the branch target is loaded and the advance is dropped.
- R9: When `ready_o` is 1 and neither request is present, `pc_o` holds its value.
- R10: Once `ready_o` has risen, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_rd_o | output | 1 | Vector read strobe |
| mem_addr_o | output | 16 | Vector byte address |
| mem_data_i | input | 8 | Byte returned by memory, valid in the same cycle as the address |
| fetch_i | input | 1 | Advance request |
| ilen_i | input | 2 | Instruction length minus one |
| br_ld_i | input | 1 | Branch load strobe |
| br_sel_i | input | 1 | Target source: 0 immediate, 1 register |
| br_imm_i | input | 16 | Immediate branch target |
| br_reg_i | input | 16 | Register branch target |
| pc_o | output | 16 | Program counter |
| ready_o | output | 1 | Vector loaded, requests accepted |

## Verification
The vector bytes are captured on the first and second edges after reset release. The bench therefore checks the read address after the first edge, and checks the loaded counter and `ready_o` after the second edge. Every advance and branch takes effect on the single edge that follows its request. The bench drives each request one nanosecond after an edge, then samples one nanosecond after the next edge, so each result is read in the one cycle where it is due. Requests held high during the vector sequence are confirmed to be dropped by comparing the loaded counter exactly against the vector.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic {
    ST_VEC = 1'b0,
    ST_RUN = 1'b1
  } pc_state_e;
endpackage

// File: rtl/pc_vec_seq.sv
module pc_vec_seq
  import pc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int VEC_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              done_o,
  output logic              ready_o
);
  localparam int NB = ADDR_W / DATA_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  pc_state_e      state_q;
  logic [IW-1:0]  idx_q;
  logic           last;

  assign last    = (idx_q == IW'(NB - 1));
  assign rd_o    = (state_q == ST_VEC);
  assign done_o  = rd_o && last;
  assign ready_o = (state_q == ST_RUN);
  assign addr_o  = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_VEC;
      idx_q   <= '0;
    end else if (state_q == ST_VEC) begin
      if (last) begin
        state_q <= ST_RUN;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // lower bytes are registered; the top byte is taken straight from memory
  for (genvar k = 0; k < NB; k++) begin : g_byte
    if (k < NB - 1) begin : g_lo
      logic [DATA_W-1:0] b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          b_q <= '0;
        else if (rd_o && idx_q == IW'(k))     b_q <= data_i;
      end
      assign vec_o[k*DATA_W +: DATA_W] = b_q;
    end else begin : g_hi
      assign vec_o[k*DATA_W +: DATA_W] = data_i;
    end
  end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              ready_i,
  input  logic              vec_done_i,
  input  logic [ADDR_W-1:0] vec_i,
  input  logic              fetch_i,
  input  logic [LEN_W-1:0]  ilen_i,
  input  logic              br_ld_i,
  input  logic              br_sel_i,
  input  logic [ADDR_W-1:0] br_imm_i,
  input  logic [ADDR_W-1:0] br_reg_i,
  output logic              pc_en_o,
  output logic [ADDR_W-1:0] pc_d_o
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] tgt;

  assign step = ADDR_W'(ilen_i) + ADDR_W'(1);
  assign tgt  = br_sel_i ? br_reg_i : br_imm_i;

  always_comb begin
    pc_en_o = 1'b0;
    pc_d_o  = pc_i;
    if (vec_done_i) begin
      pc_en_o = 1'b1;
      pc_d_o  = vec_i;
    end else if (ready_i) begin
      if (br_ld_i) begin
        pc_en_o = 1'b1;
        pc_d_o  = tgt;
      end else if (fetch_i) begin
        pc_en_o = 1'b1;
        pc_d_o  = pc_i + step;   // wraps modulo 2**ADDR_W
      end
    end
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 2,
  parameter int VEC_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              fetch_i,
  input  logic [LEN_W-1:0]  ilen_i,
  input  logic              br_ld_i,
  input  logic              br_sel_i,
  input  logic [ADDR_W-1:0] br_imm_i,
  input  logic [ADDR_W-1:0] br_reg_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ready_o
);
  logic [ADDR_W-1:0] pc_q, pc_d, vec;
  logic              pc_en, vec_done, ready;

  pc_vec_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (mem_data_i),
    .rd_o    (mem_rd_o),
    .addr_o  (mem_addr_o),
    .vec_o   (vec),
    .done_o  (vec_done),
    .ready_o (ready)
  );

  pc_next_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next (
    .pc_i       (pc_q),
    .ready_i    (ready),
    .vec_done_i (vec_done),
    .vec_i      (vec),
    .fetch_i    (fetch_i),
    .ilen_i     (ilen_i),
    .br_ld_i    (br_ld_i),
    .br_sel_i   (br_sel_i),
    .br_imm_i   (br_imm_i),
    .br_reg_i   (br_reg_i),
    .pc_en_o    (pc_en),
    .pc_d_o     (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o    = pc_q;
  assign ready_o = ready;
endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_o,
  input logic              fetch_i,
  input logic [LEN_W-1:0]  ilen_i,
  input logic              br_ld_i,
  input logic              br_sel_i,
  input logic [ADDR_W-1:0] br_imm_i,
  input logic [ADDR_W-1:0] br_reg_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ready_o
);
  // R2
  rd_vs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o != ready_o);

  // R4
  hold_until_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (ready_o || pc_o == $past(pc_o)));

  // R5
  advance_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && fetch_i && !br_ld_i) |=>
      pc_o == $past(pc_o) + ADDR_W'($past(ilen_i)) + ADDR_W'(1));

  // R7
  branch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && br_ld_i) |=>
      pc_o == ($past(br_sel_i) ? $past(br_reg_i) : $past(br_imm_i)));

  // R8
  branch_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && br_ld_i && fetch_i && !br_sel_i) |=> pc_o == $past(br_imm_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !br_ld_i && !fetch_i) |=> $stable(pc_o));

  // R10
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

bind pc_unit pc_unit_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_rd_o (mem_rd_o),
  .fetch_i  (fetch_i),
  .ilen_i   (ilen_i),
  .br_ld_i  (br_ld_i),
  .br_sel_i (br_sel_i),
  .br_imm_i (br_imm_i),
  .br_reg_i (br_reg_i),
  .pc_o     (pc_o),
  .ready_o  (ready_o)
);

// File: tb/pc_unit_bench.sv
`timescale 1ns/1ps
module pc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        fetch = 1'b0;
  logic [1:0]  ilen = 2'd0;
  logic        br_ld = 1'b0;
  logic        br_sel = 1'b0;
  logic [15:0] br_imm = 16'h0;
  logic [15:0] br_reg = 16'h0;
  logic [15:0] pc;
  logic        ready;
  logic [7:0]  vec_lo = 8'h00;
  logic [7:0]  vec_hi = 8'h00;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    if (mem_addr == 16'h0000)      mem_data = vec_lo;
    else if (mem_addr == 16'h0001) mem_data = vec_hi;
    else                           mem_data = 8'h5A;
  end

  pc_unit u_pc_unit (
    .clk_i(clk), .rst_ni(rst_ni), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .fetch_i(fetch), .ilen_i(ilen), .br_ld_i(br_ld),
    .br_sel_i(br_sel), .br_imm_i(br_imm), .br_reg_i(br_reg),
    .pc_o(pc), .ready_o(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    #1;
    check("R1 pc", 32'(pc), 32'h0);
    check("R1 ready", 32'(ready), 32'h0);
    check("R1 rd", 32'(mem_rd), 32'h1);
    check("R1 addr", 32'(mem_addr), 32'h0);
  endtask

  // reset release with requests held high to confirm they are dropped (R4)
  task automatic t_vector(input logic [7:0] lo, input logic [7:0] hi);
    vec_lo = lo;
    vec_hi = hi;
    rst_ni = 1'b0;
    cyc();
    fetch = 1'b1; ilen = 2'd3; br_ld = 1'b1; br_sel = 1'b0; br_imm = 16'h7777;
    rst_ni = 1'b1;
    cyc();
    check("R2 addr hi", 32'(mem_addr), 32'h1);
    check("R2 rd", 32'(mem_rd), 32'h1);
    check("R4 pc held", 32'(pc), 32'h0);
    check("R3 not ready yet", 32'(ready), 32'h0);
    cyc();
    check("R3 ready", 32'(ready), 32'h1);
    check("R3 R4 vector", 32'(pc), 32'({hi, lo}));
    check("R2 rd off", 32'(mem_rd), 32'h0);
    fetch = 1'b0; br_ld = 1'b0;
  endtask

  task automatic t_advance();
    for (int c = 0; c < 4; c++) begin
      logic [15:0] prev;
      prev = pc;
      fetch = 1'b1; ilen = 2'(c);
      cyc();
      check("R5 advance", 32'(pc), 32'(16'(prev + 16'(c) + 16'd1)));
    end
    fetch = 1'b0;
  endtask

  task automatic t_hold();
    logic [15:0] prev;
    prev = pc;
    for (int i = 0; i < 3; i++) cyc();
    check("R9 hold", 32'(pc), 32'(prev));
    check("R10 ready", 32'(ready), 32'h1);
  endtask

  task automatic t_branch();
    br_imm = 16'h1234; br_reg = 16'hABCD;
    br_ld = 1'b1; br_sel = 1'b0;
    cyc();
    check("R7 imm", 32'(pc), 32'h1234);
    br_sel = 1'b1;
    cyc();
    check("R7 reg", 32'(pc), 32'hABCD);
    br_ld = 1'b0;
  endtask

  task automatic t_prio();
    br_imm = 16'h4000; br_sel = 1'b0; br_ld = 1'b1; fetch = 1'b1; ilen = 2'd2;
    cyc();
    check("R8 branch wins", 32'(pc), 32'h4000);
    br_ld = 1'b0; fetch = 1'b0;
  endtask

  task automatic t_wrap();
    br_imm = 16'hFFFE; br_sel = 1'b0; br_ld = 1'b1;
    cyc();
    br_ld = 1'b0; fetch = 1'b1; ilen = 2'd3;
    cyc();
    check("R6 wrap", 32'(pc), 32'h0002);
    fetch = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset_state();
    t_vector(8'h34, 8'hC2);
    t_advance();
    t_hold();
    t_branch();
    t_prio();
    t_wrap();
    t_reset_state();
    t_vector(8'hFF, 8'h01);
    t_advance();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule